// File: doc/BRIEF.md
# Interrupt Flag Register Bank

This block keeps eight sticky interrupt flags behind a small byte-wide register bus. Hardware event pulses set the flags. A flag stays set until software clears it. To clear flags, software writes a byte that has a zero in each position it wants cleared and ones everywhere else. A one in a written byte leaves that flag as it was. Two of the flags are not driven by an event line. They come from comparing flash-write activity with the busy window of the compute engine. One marks a flash write requested while the engine is busy. The other marks an engine pass that starts while a flash write is still running.

A second register shows the live level of seven external interrupt lines, with no latching. Its top bit is a strobe: writing a one there sends a one-cycle pulse to the watchdog. A registered interrupt output goes high when any flag is set whose bit is also set in an enable mask input.

Top module: `intflag_bank`

## Requirements
- R1: After a synchronous active-high reset, all eight flags read 0 and `irqOut` and `wdtKick` are 0. The flag bit positions are: 0 transfer-busy, 1 one-second tick, 2 collision 0, 3 collision 1, 4 pushbutton wake, 5 autowake timer, 6 PLL rise, 7 PLL fall.
- R2: A flag whose event input is high at a clock edge reads 1 after that edge. It stays 1 for as long as no write clears it.
- R3: A write to `FLAG_ADDR` clears each flag whose data bit is 0. Each flag whose data bit is 1 is left unchanged.
- R4: If a flag's event and a clearing write to that bit arrive at the same edge, the flag is 1 after the edge.
- R5: Collision 0 (bit 2) sets at any edge where `flashWrReq` and `ceBusy` are both high.
- R6: Collision 1 (bit 3) sets at any edge where `cePassStart` and `flashWrActive` are both high.
- R7: A read of `EXT_ADDR` returns `extIrq` unlatched on bits 6:0 and 0 on bit 7. A write to `EXT_ADDR` does not change the flags.
- R8: `wdtKick` is high for exactly the cycle after an edge where a write to `EXT_ADDR` had data bit 7 set. It is low after every other edge.
- R9: After each edge, `irqOut` equals the OR over all bits of (flags AND `irqEnable`), taken from the values present before that edge.
- R10: A read of any address other than the two registers returns 0. A write to such an address changes no flag and causes no `wdtKick` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busWe | input | 1 | Single-cycle write strobe |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from the addressed register |
| xferEvt | input | 1 | Transfer-busy event pulse |
| rtcEvt | input | 1 | One-second tick event pulse |
| pbEvt | input | 1 | Pushbutton wake event pulse |
| wakeEvt | input | 1 | Autowake timer event pulse |
| pllRiseEvt | input | 1 | PLL rise event pulse |
| pllFallEvt | input | 1 | PLL fall event pulse |
| flashWrReq | input | 1 | Flash write requested this cycle |
| flashWrActive | input | 1 | Flash write in progress |
| ceBusy | input | 1 | Compute engine busy window |
| cePassStart | input | 1 | Compute engine begins a pass |
| extIrq | input | NUM_EXT | Live external interrupt lines |
| irqEnable | input | 8 | Per-flag interrupt enable mask |
| irqOut | output | 1 | Registered interrupt request |
| wdtKick | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench uses the default parameters: a 4-bit address with the flag register at 0x8 and the line register at 0xC, which leaves fourteen unmapped addresses for R10. Random addresses are drawn from the full 4-bit space. Event inputs fire at a low rate and writes carry random masks. This produces many cycles where a set and a clear hit the same bit, and cycles where both collision windows overlap. It also produces back-to-back watchdog strobes and enable masks that hide a set flag.

// File: rtl/intflag_pkg.sv
package intflag_pkg;
  localparam int REG_W = 8;

  localparam int FLG_XFER  = 0;
  localparam int FLG_RTC   = 1;
  localparam int FLG_COLL0 = 2;
  localparam int FLG_COLL1 = 3;
  localparam int FLG_PB    = 4;
  localparam int FLG_WAKE  = 5;
  localparam int FLG_PLLR  = 6;
  localparam int FLG_PLLF  = 7;

  localparam int WDT_BIT = REG_W - 1;

  typedef struct packed {
    logic flagWr;
    logic selFlag;
    logic selExt;
    logic wdtReq;
  } busStrobe_t;
endpackage

// File: rtl/intflag_ctrl.sv
module intflag_ctrl
  import intflag_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h8,
  parameter logic [ADDR_W-1:0] EXT_ADDR  = 'hC
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wdtBit,
  output busStrobe_t        strb
);
  logic hitFlag;
  logic hitExt;

  always_comb begin
    hitFlag      = (busAddr == FLAG_ADDR);
    hitExt       = (busAddr == EXT_ADDR);
    strb.selFlag = hitFlag;
    strb.selExt  = hitExt;
    strb.flagWr  = busWe && hitFlag;
    strb.wdtReq  = busWe && hitExt && wdtBit;
  end
endmodule

// File: rtl/intflag_datapath.sv
module intflag_datapath
  import intflag_pkg::*;
#(
  parameter int NUM_EXT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  busStrobe_t         strb,
  input  logic [REG_W-1:0]   busWdata,
  input  logic               xferEvt,
  input  logic               rtcEvt,
  input  logic               pbEvt,
  input  logic               wakeEvt,
  input  logic               pllRiseEvt,
  input  logic               pllFallEvt,
  input  logic               flashWrReq,
  input  logic               flashWrActive,
  input  logic               ceBusy,
  input  logic               cePassStart,
  input  logic [NUM_EXT-1:0] extIrq,
  input  logic [REG_W-1:0]   irqEnable,
  output logic [REG_W-1:0]   flagQ,
  output logic [REG_W-1:0]   busRdata,
  output logic               irqOut,
  output logic               wdtKick
);
  localparam int EXT_PAD = REG_W - NUM_EXT;

  logic [REG_W-1:0] setVec;
  logic [REG_W-1:0] keepMask;
  logic [REG_W-1:0] extView;

  always_comb begin
    setVec            = '0;
    setVec[FLG_XFER]  = xferEvt;
    setVec[FLG_RTC]   = rtcEvt;
    setVec[FLG_COLL0] = flashWrReq && ceBusy;
    setVec[FLG_COLL1] = cePassStart && flashWrActive;
    setVec[FLG_PB]    = pbEvt;
    setVec[FLG_WAKE]  = wakeEvt;
    setVec[FLG_PLLR]  = pllRiseEvt;
    setVec[FLG_PLLF]  = pllFallEvt;
    keepMask          = strb.flagWr ? busWdata : {REG_W{1'b1}};
  end

  // One cell per flag; a set outranks a clear in the same cycle.
  for (genvar i = 0; i < REG_W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flagQ[i] <= 1'b0;
      else     flagQ[i] <= setVec[i] | (flagQ[i] & keepMask[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqOut  <= 1'b0;
      wdtKick <= 1'b0;
    end else begin
      irqOut  <= |(flagQ & irqEnable);
      wdtKick <= strb.wdtReq;
    end
  end

  assign extView = {{EXT_PAD{1'b0}}, extIrq};

  always_comb begin
    if (strb.selFlag)     busRdata = flagQ;
    else if (strb.selExt) busRdata = extView;
    else                  busRdata = '0;
  end
endmodule

// File: rtl/intflag_bank.sv
module intflag_bank
  import intflag_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_EXT = 7,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h8,
  parameter logic [ADDR_W-1:0] EXT_ADDR  = 'hC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [7:0]         busWdata,
  output logic [7:0]         busRdata,
  input  logic               xferEvt,
  input  logic               rtcEvt,
  input  logic               pbEvt,
  input  logic               wakeEvt,
  input  logic               pllRiseEvt,
  input  logic               pllFallEvt,
  input  logic               flashWrReq,
  input  logic               flashWrActive,
  input  logic               ceBusy,
  input  logic               cePassStart,
  input  logic [NUM_EXT-1:0] extIrq,
  input  logic [7:0]         irqEnable,
  output logic               irqOut,
  output logic               wdtKick
);
  busStrobe_t       strb;
  logic [REG_W-1:0] flagQ;

  intflag_ctrl #(
    .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .EXT_ADDR(EXT_ADDR)
  ) u_ctrl (
    .busWe(busWe), .busAddr(busAddr), .wdtBit(busWdata[WDT_BIT]), .strb(strb)
  );

  intflag_datapath #(.NUM_EXT(NUM_EXT)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .busWdata(busWdata),
    .xferEvt(xferEvt), .rtcEvt(rtcEvt), .pbEvt(pbEvt), .wakeEvt(wakeEvt),
    .pllRiseEvt(pllRiseEvt), .pllFallEvt(pllFallEvt),
    .flashWrReq(flashWrReq), .flashWrActive(flashWrActive),
    .ceBusy(ceBusy), .cePassStart(cePassStart),
    .extIrq(extIrq), .irqEnable(irqEnable),
    .flagQ(flagQ), .busRdata(busRdata), .irqOut(irqOut), .wdtKick(wdtKick)
  );
endmodule

// File: rtl/intflag_bank_checker.sv
module intflag_bank_checker #(
  parameter int ADDR_W  = 4,
  parameter int NUM_EXT = 7,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h8,
  parameter logic [ADDR_W-1:0] EXT_ADDR  = 'hC
) (
  input logic               clk,
  input logic               rst,
  input logic               busWe,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [7:0]         busWdata,
  input logic [7:0]         busRdata,
  input logic               xferEvt,
  input logic               flashWrReq,
  input logic               flashWrActive,
  input logic               ceBusy,
  input logic               cePassStart,
  input logic [NUM_EXT-1:0] extIrq,
  input logic [7:0]         irqEnable,
  input logic [7:0]         flagQ,
  input logic               irqOut,
  input logic               wdtKick
);
  logic [7:0] keep;
  logic       kickReq;
  assign keep    = (busWe && busAddr == FLAG_ADDR) ? busWdata : 8'hFF;
  assign kickReq = busWe && busAddr == EXT_ADDR && busWdata[7];

  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flagQ & $past(flagQ & keep)) == $past(flagQ & keep)));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    xferEvt |=> flagQ[0]);

  p_coll0_r5: assert property (@(posedge clk) disable iff (rst)
    (flashWrReq && ceBusy) |=> flagQ[2]);

  p_coll1_r6: assert property (@(posedge clk) disable iff (rst)
    (cePassStart && flashWrActive) |=> flagQ[3]);

  p_ext_read_r7: assert property (@(posedge clk) disable iff (rst)
    (busAddr == EXT_ADDR) |-> (busRdata[7] == 1'b0 && busRdata[NUM_EXT-1:0] == extIrq));

  p_kick_on_r8: assert property (@(posedge clk) disable iff (rst)
    kickReq |=> wdtKick);

  p_kick_off_r8: assert property (@(posedge clk) disable iff (rst)
    !kickReq |=> !wdtKick);

  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irqOut == $past(|(flagQ & irqEnable))));

  p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    (busAddr != FLAG_ADDR && busAddr != EXT_ADDR) |-> (busRdata == 8'h00));
endmodule

bind intflag_bank intflag_bank_checker #(
  .ADDR_W(ADDR_W), .NUM_EXT(NUM_EXT), .FLAG_ADDR(FLAG_ADDR), .EXT_ADDR(EXT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
  .busRdata(busRdata), .xferEvt(xferEvt), .flashWrReq(flashWrReq),
  .flashWrActive(flashWrActive), .ceBusy(ceBusy), .cePassStart(cePassStart),
  .extIrq(extIrq), .irqEnable(irqEnable), .flagQ(flagQ), .irqOut(irqOut),
  .wdtKick(wdtKick)
);

// File: tb/intflag_bank_tb.sv
`timescale 1ns/1ps
module intflag_bank_tb;
  localparam logic [3:0] FA = 4'h8;
  localparam logic [3:0] EA = 4'hC;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst;
  logic       busWe;
  logic [3:0] busAddr;
  logic [7:0] busWdata;
  logic [7:0] busRdata;
  logic xferEvt, rtcEvt, pbEvt, wakeEvt, pllRiseEvt, pllFallEvt;
  logic flashWrReq, flashWrActive, ceBusy, cePassStart;
  logic [6:0] extIrq;
  logic [7:0] irqEnable;
  logic irqOut, wdtKick;

  intflag_bank u_dut (
    .clk(clk), .rst(rst), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .xferEvt(xferEvt), .rtcEvt(rtcEvt), .pbEvt(pbEvt),
    .wakeEvt(wakeEvt), .pllRiseEvt(pllRiseEvt), .pllFallEvt(pllFallEvt),
    .flashWrReq(flashWrReq), .flashWrActive(flashWrActive), .ceBusy(ceBusy),
    .cePassStart(cePassStart), .extIrq(extIrq), .irqEnable(irqEnable),
    .irqOut(irqOut), .wdtKick(wdtKick)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] model;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] setOf();
    logic [7:0] s;
    s = {pllFallEvt, pllRiseEvt, wakeEvt, pbEvt,
         cePassStart & flashWrActive, flashWrReq & ceBusy, rtcEvt, xferEvt};
    return s;
  endfunction

  function automatic logic [7:0] nextFlags(input logic [7:0] f);
    logic [7:0] keep;
    keep = (busWe && busAddr == FA) ? busWdata : 8'hFF;
    return setOf() | (f & keep);
  endfunction

  function automatic logic [7:0] readExp(input logic [7:0] f);
    if (busAddr == FA) return f;
    if (busAddr == EA) return {1'b0, extIrq};
    return 8'h00;
  endfunction

  task automatic idle();
    busWe = 0; busAddr = 4'h0; busWdata = 8'h00;
    {xferEvt, rtcEvt, pbEvt, wakeEvt, pllRiseEvt, pllFallEvt} = '0;
    {flashWrReq, flashWrActive, ceBusy, cePassStart} = '0;
  endtask

  // Inputs are already driven; check the read, take one edge, check outputs.
  task automatic step();
    logic [7:0] nxt;
    logic expIrq, expKick;
    #1;
    if (busAddr == FA)      chk("R3 flag read", busRdata, readExp(model));
    else if (busAddr == EA) chk("R7 line read", busRdata, readExp(model));
    else                    chk("R10 unmapped read", busRdata, 8'h00);
    nxt     = nextFlags(model);
    expIrq  = |(model & irqEnable);
    expKick = busWe && busAddr == EA && busWdata[7];
    @(posedge clk); #1;
    model = nxt;
    chk("R9 irqOut", {7'd0, irqOut}, {7'd0, expIrq});
    chk("R8 wdtKick", {7'd0, wdtKick}, {7'd0, expKick});
    @(negedge clk);
  endtask

  task automatic readFlags(input string req, input logic [7:0] exp);
    idle(); busAddr = FA; #1;
    chk(req, busRdata, exp);
    step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    rst = 1; idle(); extIrq = 7'h00; irqEnable = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    model = 8'h00;
    // R1: reset state
    busAddr = FA; #1;
    chk("R1 flags after reset", busRdata, 8'h00);
    chk("R1 irqOut after reset", {7'd0, irqOut}, 8'h00);
    chk("R1 wdtKick after reset", {7'd0, wdtKick}, 8'h00);
    // R1/R2: one-second tick lands on bit 1 and stays
    idle(); rtcEvt = 1; step();
    readFlags("R1 tick on bit 1", 8'h02);
    readFlags("R2 stays set", 8'h02);
    // R3: write zero clears, ones keep
    idle(); pbEvt = 1; step();
    idle(); busWe = 1; busAddr = FA; busWdata = 8'hFD; step();
    readFlags("R3 clear bit 1 keep bit 4", 8'h10);
    // R4: set and clear of bit 0 in one cycle
    idle(); xferEvt = 1; busWe = 1; busAddr = FA; busWdata = 8'h00; step();
    readFlags("R4 set wins, bit 4 cleared", 8'h01);
    // R5 and R6
    idle(); busWe = 1; busAddr = FA; busWdata = 8'h00; step();
    idle(); flashWrReq = 1; step();
    idle(); ceBusy = 1; step();
    readFlags("R5 no collision on one side alone", 8'h00);
    idle(); flashWrReq = 1; ceBusy = 1; step();
    readFlags("R5 collision 0", 8'h04);
    idle(); cePassStart = 1; flashWrActive = 1; step();
    readFlags("R6 collision 1", 8'h0C);
    // R7: line read and write to line register leaves flags
    idle(); extIrq = 7'h5A; busAddr = EA; #1;
    chk("R7 live lines", busRdata, 8'h5A);
    extIrq = 7'h7F; #1;
    chk("R7 bit 7 reads 0", busRdata, 8'h7F);
    idle(); busWe = 1; busAddr = EA; busWdata = 8'h00; step();
    readFlags("R7 write to line reg keeps flags", 8'h0C);
    // R8: back-to-back watchdog strobes
    idle(); busWe = 1; busAddr = EA; busWdata = 8'h80; step();
    idle(); busWe = 1; busAddr = EA; busWdata = 8'h80; step();
    idle(); step();
    // R9: enable hides then reveals
    irqEnable = 8'h01; idle(); step();
    chk("R9 masked irq low", {7'd0, irqOut}, 8'h00);
    irqEnable = 8'h04; idle(); step();
    chk("R9 enabled irq high", {7'd0, irqOut}, 8'h01);
    // R10: writes to unmapped addresses ignored
    idle(); busWe = 1; busAddr = 4'h3; busWdata = 8'h00; step();
    idle(); busWe = 1; busAddr = 4'hF; busWdata = 8'hFF; step();
    readFlags("R10 unmapped write ignored", 8'h0C);
    // Random phase
    for (int n = 0; n < 3000; n++) begin
      busWe      = ($urandom % 3) == 0;
      busAddr    = ($urandom % 2) ? (($urandom % 2) ? FA : EA) : 4'($urandom);
      busWdata   = 8'($urandom);
      xferEvt    = ($urandom % 8) == 0;
      rtcEvt     = ($urandom % 8) == 0;
      pbEvt      = ($urandom % 8) == 0;
      wakeEvt    = ($urandom % 8) == 0;
      pllRiseEvt = ($urandom % 8) == 0;
      pllFallEvt = ($urandom % 8) == 0;
      flashWrReq    = ($urandom % 3) == 0;
      flashWrActive = ($urandom % 3) == 0;
      ceBusy        = ($urandom % 3) == 0;
      cePassStart   = ($urandom % 3) == 0;
      extIrq     = 7'($urandom);
      irqEnable  = 8'($urandom);
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule